// File: doc/BRIEF.md
# Fixed-Point Load Address Generator and Result Formatter

This block sits behind the decode stage of a 64-bit fixed-point core. It receives one decoded load operation, which carries these fields:

- the access size
- a sign-extension request
- a byte-reversal request
- the address form: register-indexed, or an immediate of one of three scalings
- an update flag
- the two register operand values
- the base and target register numbers
- the raw 16-bit immediate field

The block forms the effective address and issues one read on a byte-addressed synchronous memory port. It then shapes the returned bytes into a 64-bit result for the target register. For update forms it also produces a write of the effective address back to the base register.

Operations enter through a valid/ready handshake. `req_ready` is high only while the unit is idle, so a request presented while it is busy is held off until the current one finishes. Completion is reported by a one-cycle `done` strobe. The strobe comes with the register write enables, the register numbers and the data. The result side has no back-pressure: the consumer must take the write in the strobe cycle.

An update form that names register 0 as its base, or names the same register as base and target, is not executed. In that case the block reports `illegal` with `done`, makes no memory access and asserts no write enable.

Top module: `ldfmt_unit`

## Requirements
- R1: For non-update operations, the base is `req_ra_val`, except when `req_ra_sel` is 0; then the base is zero.
- R2: For immediate forms, the effective address is base plus the sign-extended 16-bit immediate. `req_imm_kind` selects how the immediate is read:
  - 0: the immediate is used as given.
  - 1: the two low immediate bits are ignored and taken as zero.
  - 2: the four low immediate bits are ignored and taken as zero.
  - 3: the immediate is used as given, as for 0.
- R3: When `req_indexed` is 1, the effective address is base plus `req_rb_val`, and the immediate is ignored.
- R4: The access size is coded in `req_size`: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. A plain load places the loaded value in the low bits of `rt_data` and clears the upper bits. The byte at the effective address is the most significant byte of the loaded value.
- R5: When `req_sext` is 1 and the size is 2 or 4 bytes, the loaded value is sign-extended to 64 bits. For 1-byte and 8-byte sizes, `req_sext` has no effect.
- R6: When `req_brev` is 1, the byte order of the loaded value is reversed, so the byte at the effective address becomes the least significant byte. The reversed value is zero-extended, and byte reversal overrides `req_sext`.
- R7: An update operation always uses `req_ra_val` as its base. When it completes, it asserts `ra_we`, with `ra_sel` equal to the base register number and `ra_data` equal to the effective address.
- R8: An update operation whose base register number is 0, or equals its target register number, is flagged as illegal:
  - `done` and `illegal` pulse in the cycle after acceptance.
  - `rt_we` and `ra_we` stay low.
  - `mem_rd_en` never rises for it.
- R9: Timing of a legal operation:
  - `mem_rd_en` is high for exactly the one cycle after acceptance, with `mem_addr` equal to the effective address and `mem_size` equal to the size code.
  - The memory returns `mem_rdata` one cycle after the read. The 8N loaded bits are right-aligned, with the addressed byte most significant.
  - `done` and `rt_we` pulse for one cycle, two cycles after the read cycle.
  - `req_ready` is low from acceptance until the cycle after `done`.
- R10: After reset, `req_ready` is high and `done`, `illegal`, `mem_rd_en`, `rt_we` and `ra_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load operation offered |
| req_ready | output | 1 | Unit idle, operation accepted when valid |
| req_size | input | 2 | Access size code (1/2/4/8 bytes) |
| req_sext | input | 1 | Sign-extend 2- and 4-byte results |
| req_brev | input | 1 | Reverse byte order of the loaded value |
| req_indexed | input | 1 | Offset from register instead of immediate |
| req_update | input | 1 | Write effective address back to base register |
| req_imm_kind | input | 2 | Immediate scaling: as-is, low 2 zero, low 4 zero |
| req_imm | input | 16 | Raw immediate field |
| req_ra_sel | input | 5 | Base register number |
| req_rt_sel | input | 5 | Target register number |
| req_ra_val | input | 64 | Base register contents |
| req_rb_val | input | 64 | Index register contents |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 64 | Byte address of the read |
| mem_size | output | 2 | Size code of the read |
| mem_rdata | input | 64 | Read data, right-aligned, one cycle after the strobe |
| done | output | 1 | Operation complete strobe |
| illegal | output | 1 | Completed operation had an invalid update form |
| rt_we | output | 1 | Target register write enable |
| rt_sel | output | 5 | Target register number |
| rt_data | output | 64 | Formatted load result |
| ra_we | output | 1 | Base register write enable (update forms) |
| ra_sel | output | 5 | Base register number |
| ra_data | output | 64 | Effective address for the base register write |

## Verification
Take the clock edge that accepts a legal operation as edge 0. Its read strobe and address are due in the cycle after that edge. Nothing is due after edge 1. The `done`, result and write-back outputs are due after edge 2. An illegal update form instead completes right after edge 0. The bench samples on falling edges and checks each output only in the cycle where it is due. It also checks that `done` and `mem_rd_en` are low in the cycles between. A sweep covers every combination of the following, with per-operation register and immediate values that set the immediate's low bits:
- size
- sign-extension request
- byte-reversal request
- indexed or immediate form
- update flag
- immediate scaling
- three base register numbers

The expected address and data are computed arithmetically from a hash-filled byte memory.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    IMM_PLAIN = 2'd0,
    IMM_SCL4  = 2'd1,
    IMM_SCL16 = 2'd2,
    IMM_RSVD  = 2'd3
  } imm_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } ld_state_e;

  typedef struct packed {
    ld_size_e size;
    logic     sext;
    logic     brev;
    logic     update;
    logic     illegal;
  } ld_ctl_t;

endpackage

// File: rtl/ldfmt_agen.sv
module ldfmt_agen
  import ldfmt_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REGW = 5,
  parameter int IMMW = 16
) (
  input  logic            update,
  input  logic            indexed,
  input  imm_kind_e       imm_kind,
  input  logic [REGW-1:0] ra_sel,
  input  logic [REGW-1:0] rt_sel,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] ea,
  output logic            bad_form
);

  localparam int EXTW = XLEN - IMMW;

  logic [IMMW-1:0] imm_m;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  // Scaled immediates: low bits belong to the opcode, forced to zero
  always_comb begin
    case (imm_kind)
      IMM_SCL4:  imm_m = {imm[IMMW-1:2], 2'b00};
      IMM_SCL16: imm_m = {imm[IMMW-1:4], 4'b0000};
      default:   imm_m = imm;
    endcase
  end

  // Register 0 as base reads as zero unless the form updates the base
  assign base     = (update || (ra_sel != '0)) ? ra_val : '0;
  assign offs     = indexed ? rb_val : {{EXTW{imm_m[IMMW-1]}}, imm_m};
  assign ea       = base + offs;
  assign bad_form = update && ((ra_sel == '0) || (ra_sel == rt_sel));

endmodule

// File: rtl/ldfmt_format.sv
module ldfmt_format
  import ldfmt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  ld_size_e        size,
  input  logic            sext,
  input  logic            brev,
  output logic [XLEN-1:0] result
);

  localparam int NBYTE = XLEN / 8;

  logic [7:0]      norm_lane [NBYTE];
  logic [7:0]      rev_lane  [NBYTE];
  logic [XLEN-1:0] norm_flat;
  logic [XLEN-1:0] rev_flat;
  logic [XLEN-1:0] chosen;

  // Lane g is bits 8g+7:8g; lanes beyond the access size read as zero
  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    always_comb begin
      int nb;
      nb = 1 << int'(size);
      if (g < nb) begin
        norm_lane[g] = raw[8*g +: 8];
        rev_lane[g]  = raw[8*(nb-1-g) +: 8];
      end else begin
        norm_lane[g] = 8'h00;
        rev_lane[g]  = 8'h00;
      end
    end
    assign norm_flat[8*g +: 8] = norm_lane[g];
    assign rev_flat[8*g +: 8]  = rev_lane[g];
  end

  assign chosen = brev ? rev_flat : norm_flat;

  always_comb begin
    result = chosen;
    if (sext && !brev) begin
      case (size)
        SZ_HALF: result = {{(XLEN-16){chosen[15]}}, chosen[15:0]};
        SZ_WORD: result = {{(XLEN-32){chosen[31]}}, chosen[31:0]};
        default: result = chosen;
      endcase
    end
  end

endmodule

// File: rtl/ldfmt_unit.sv
module ldfmt_unit
  import ldfmt_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REGW = 5,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_size,
  input  logic            req_sext,
  input  logic            req_brev,
  input  logic            req_indexed,
  input  logic            req_update,
  input  logic [1:0]      req_imm_kind,
  input  logic [IMMW-1:0] req_imm,
  input  logic [REGW-1:0] req_ra_sel,
  input  logic [REGW-1:0] req_rt_sel,
  input  logic [XLEN-1:0] req_ra_val,
  input  logic [XLEN-1:0] req_rb_val,
  output logic            mem_rd_en,
  output logic [XLEN-1:0] mem_addr,
  output logic [1:0]      mem_size,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done,
  output logic            illegal,
  output logic            rt_we,
  output logic [REGW-1:0] rt_sel,
  output logic [XLEN-1:0] rt_data,
  output logic            ra_we,
  output logic [REGW-1:0] ra_sel,
  output logic [XLEN-1:0] ra_data
);

  ld_state_e       state;
  ld_ctl_t         ctl_q;
  logic [XLEN-1:0] ea_q;
  logic [XLEN-1:0] res_q;
  logic [REGW-1:0] ra_q;
  logic [REGW-1:0] rt_q;
  logic [XLEN-1:0] ea_c;
  logic            bad_c;
  logic [XLEN-1:0] fmt_c;
  logic            accept;

  ldfmt_agen #(.XLEN(XLEN), .REGW(REGW), .IMMW(IMMW)) u_agen (
    .update   (req_update),
    .indexed  (req_indexed),
    .imm_kind (imm_kind_e'(req_imm_kind)),
    .ra_sel   (req_ra_sel),
    .rt_sel   (req_rt_sel),
    .ra_val   (req_ra_val),
    .rb_val   (req_rb_val),
    .imm      (req_imm),
    .ea       (ea_c),
    .bad_form (bad_c)
  );

  ldfmt_format #(.XLEN(XLEN)) u_fmt (
    .raw    (mem_rdata),
    .size   (ctl_q.size),
    .sext   (ctl_q.sext),
    .brev   (ctl_q.brev),
    .result (fmt_c)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ctl_q <= '0;
      ea_q  <= '0;
      res_q <= '0;
      ra_q  <= '0;
      rt_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ctl_q.size    <= ld_size_e'(req_size);
            ctl_q.sext    <= req_sext;
            ctl_q.brev    <= req_brev;
            ctl_q.update  <= req_update;
            ctl_q.illegal <= bad_c;
            ea_q          <= ea_c;
            ra_q          <= req_ra_sel;
            rt_q          <= req_rt_sel;
            state         <= bad_c ? ST_DONE : ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          res_q <= fmt_c;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en = (state == ST_ISSUE);
  assign mem_addr  = ea_q;
  assign mem_size  = ctl_q.size;
  assign done      = (state == ST_DONE);
  assign illegal   = done && ctl_q.illegal;
  assign rt_we     = done && !ctl_q.illegal;
  assign ra_we     = rt_we && ctl_q.update;
  assign rt_sel    = rt_q;
  assign ra_sel    = ra_q;
  assign rt_data   = res_q;
  assign ra_data   = ea_q;

endmodule

// File: rtl/ldfmt_unit_chk.sv
module ldfmt_unit_chk #(
  parameter int XLEN = 64,
  parameter int REGW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_update,
  input logic [REGW-1:0] req_ra_sel,
  input logic [REGW-1:0] req_rt_sel,
  input logic            mem_rd_en,
  input logic [XLEN-1:0] mem_addr,
  input logic            done,
  input logic            illegal,
  input logic            rt_we,
  input logic            ra_we,
  input logic [XLEN-1:0] ra_data
);

  logic acc_bad;
  logic acc_ok;

  assign acc_bad = req_valid && req_ready && req_update &&
                   ((req_ra_sel == '0) || (req_ra_sel == req_rt_sel));
  assign acc_ok  = req_valid && req_ready && !acc_bad;

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R9
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready); // R9
  AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> mem_rd_en); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BAD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> (!mem_rd_en && done && illegal)); // R8
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rt_we && !ra_we)); // R8
  AST_UPD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ra_we |-> (ra_data == $past(mem_addr, 2))); // R7

endmodule

bind ldfmt_unit ldfmt_unit_chk #(.XLEN(XLEN), .REGW(REGW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_update (req_update),
  .req_ra_sel (req_ra_sel),
  .req_rt_sel (req_rt_sel),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .done       (done),
  .illegal    (illegal),
  .rt_we      (rt_we),
  .ra_we      (ra_we),
  .ra_data    (ra_data)
);

// File: tb/ldfmt_unit_tb_top.sv
`timescale 1ns/1ps
module ldfmt_unit_tb_top;

  localparam real HALF_NS = 10.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_size = '0;
  logic        req_sext = 1'b0;
  logic        req_brev = 1'b0;
  logic        req_indexed = 1'b0;
  logic        req_update = 1'b0;
  logic [1:0]  req_imm_kind = '0;
  logic [15:0] req_imm = '0;
  logic [4:0]  req_ra_sel = '0;
  logic [4:0]  req_rt_sel = '0;
  logic [63:0] req_ra_val = '0;
  logic [63:0] req_rb_val = '0;
  logic        mem_rd_en;
  logic [63:0] mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_rdata = '0;
  logic        done;
  logic        illegal;
  logic        rt_we;
  logic [4:0]  rt_sel;
  logic [63:0] rt_data;
  logic        ra_we;
  logic [4:0]  ra_sel;
  logic [63:0] ra_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(HALF_NS) clk = ~clk;

  ldfmt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_sext(req_sext), .req_brev(req_brev),
    .req_indexed(req_indexed), .req_update(req_update),
    .req_imm_kind(req_imm_kind), .req_imm(req_imm),
    .req_ra_sel(req_ra_sel), .req_rt_sel(req_rt_sel),
    .req_ra_val(req_ra_val), .req_rb_val(req_rb_val),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rdata(mem_rdata), .done(done), .illegal(illegal),
    .rt_we(rt_we), .rt_sel(rt_sel), .rt_data(rt_data),
    .ra_we(ra_we), .ra_sel(ra_sel), .ra_data(ra_data)
  );

  function automatic logic [7:0] mb(input logic [63:0] a);
    return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h5A ^ a[23:16];
  endfunction

  // Memory model: one-cycle latency, bytes right-aligned, addressed byte first
  always @(posedge clk) begin
    if (mem_rd_en) begin
      logic [63:0] rd;
      int n;
      rd = '0;
      n = 1 << int'(mem_size);
      for (int k = 0; k < n; k++) rd[8*(n-1-k) +: 8] = mb(mem_addr + 64'(k));
      mem_rdata <= rd;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int sz, input bit sx, input bit br, input bit ix,
                        input bit up, input int ik, input logic [15:0] imm,
                        input logic [4:0] ras, input logic [4:0] rts,
                        input logic [63:0] rav, input logic [63:0] rbv);
    logic [15:0] im;
    logic [63:0] base, ea, raw, rev, val;
    bit bad;
    int n;
    string atag, dtag;
    im   = (ik == 1) ? {imm[15:2], 2'b00} : (ik == 2) ? {imm[15:4], 4'b0000} : imm;
    base = (up || ras != 0) ? rav : 64'd0;
    ea   = base + (ix ? rbv : {{48{im[15]}}, im});
    bad  = up && (ras == 0 || ras == rts);
    n    = 1 << sz;
    raw  = '0;
    rev  = '0;
    for (int k = 0; k < n; k++) begin
      raw[8*(n-1-k) +: 8] = mb(ea + 64'(k));
      rev[8*k +: 8]       = mb(ea + 64'(k));
    end
    if (br) val = rev;
    else if (sx && sz == 1) val = {{48{raw[15]}}, raw[15:0]};
    else if (sx && sz == 2) val = {{32{raw[31]}}, raw[31:0]};
    else val = raw;
    atag = ix ? "R3 indexed EA" : (!up && ras == 0) ? "R1 zero base EA" : "R2 imm EA";
    dtag = br ? "R6 reversed data" : (sx && (sz == 1 || sz == 2)) ? "R5 sext data" : "R4 zero-ext data";

    @(negedge clk);
    req_size = 2'(sz); req_sext = sx; req_brev = br; req_indexed = ix;
    req_update = up; req_imm_kind = 2'(ik); req_imm = imm;
    req_ra_sel = ras; req_rt_sel = rts; req_ra_val = rav; req_rb_val = rbv;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R9 ready idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk(done && illegal, "R8 illegal flagged", {62'd0, done, illegal}, 64'd3);
      chk(!rt_we && !ra_we && !mem_rd_en, "R8 no write/read",
          {61'd0, rt_we, ra_we, mem_rd_en}, 64'd0);
      @(negedge clk);
      chk(req_ready && !done, "R9 idle after illegal", {62'd0, req_ready, done}, 64'd2);
    end else begin
      chk(mem_rd_en == 1'b1, "R9 read strobe", 64'(mem_rd_en), 64'd1);
      chk(mem_addr == ea, atag, mem_addr, ea);
      chk(mem_size == 2'(sz), "R9 mem size", 64'(mem_size), 64'(sz));
      chk(!req_ready, "R9 busy", 64'(req_ready), 64'd0);
      @(negedge clk);
      chk(!done && !mem_rd_en, "R9 wait cycle", {62'd0, done, mem_rd_en}, 64'd0);
      @(negedge clk);
      chk(done && rt_we && !illegal, "R9 done strobe",
          {61'd0, done, rt_we, illegal}, 64'd6);
      chk(rt_data == val, dtag, rt_data, val);
      chk(rt_sel == rts, "R4 rt sel", 64'(rt_sel), 64'(rts));
      if (up) begin
        chk(ra_we && ra_sel == ras, "R7 ra write", {58'd0, ra_we, ra_sel},
            {58'd0, 1'b1, ras});
        chk(ra_data == ea, "R7 ra data", ra_data, ea);
      end else begin
        chk(!ra_we, "R7 no ra write", 64'(ra_we), 64'd0);
      end
      @(negedge clk);
      chk(!done && req_ready, "R9 done single", {62'd0, done, req_ready}, 64'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int idx;
    logic [4:0] ra_list [3];
    ra_list[0] = 5'd0; ra_list[1] = 5'd3; ra_list[2] = 5'd7;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready && !done && !illegal && !mem_rd_en && !rt_we && !ra_we,
        "R10 reset outputs",
        {58'd0, req_ready, done, illegal, mem_rd_en, rt_we, ra_we}, 64'h20);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done, "R10 after release", {62'd0, req_ready, done}, 64'd2);
    idx = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int sx = 0; sx < 2; sx++)
        for (int br = 0; br < 2; br++)
          for (int ix = 0; ix < 2; ix++)
            for (int up = 0; up < 2; up++)
              for (int ik = 0; ik < 3; ik++)
                for (int r = 0; r < 3; r++) begin
                  logic [63:0] rav, rbv;
                  logic [15:0] imm;
                  rav = 64'h0000_1000_0000_0100 + 64'(idx * 37);
                  rbv = idx[0] ? (64'hFFFF_FFFF_FFFF_FFF0 - 64'(idx)) : 64'(idx * 13);
                  imm = idx[1] ? (16'hFF37 ^ 16'(idx)) : (16'h012B + 16'(idx));
                  run_op(sz, sx[0], br[0], ix[0], up[0], ik, imm, ra_list[r],
                         5'd7, rav, rbv);
                  idx++;
                end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule